// File: doc/BRIEF.md
# Debug Power-Reset Domain Control

This block gives debug tooling a view of, and a hand on, the power, reset and execution state of a set of dynamically controlled sub-domains. It holds one 32-bit control/status word per domain. Each word reports live status inputs from the power, clock and processor logic. It also latches reset-occurred and power-loss events until the debugger acknowledges them. It drives an encoded reset-control mode, a release strobe for an extended reset and a force-active override. A fixed identification word lets tools recognise the port.

Access is through a simple single-cycle register bus. A select with the write flag high writes; a select with it low reads, and read data is registered one cycle later. The tool may change the reset-control, release and force-active fields only while the domain's override-writable status input is high. Acknowledging a sticky event is always allowed.

Top module: `dbg_pwrdom_ctl`

## Requirements
- R1: After the synchronous active-high reset, every control output is 0, every sticky flag and stored field is 0, and a domain word with all status inputs low reads 0x0000_0000.
- R2: Bit 22 (reset occurred) is set by an `ev_core_rst` pulse and bit 21 (power loss) by an `ev_pwr_loss` pulse. Each stays set until a write with a 1 in that bit position clears it. A write with 0 there leaves it unchanged. If an event and a clearing write fall in the same cycle, the flag ends up set.
- R3: Bits 16:14 hold the reset mode. 3'b001 drives `hold_rst` high, and 3'b010 drives `block_rst` high. Any undefined code (011, 101, 110, 111) reads back as written and drives both low, like 3'b000.
- R4: Writing 3'b100 to bits 16:14 raises `rst_req` for exactly the one cycle after the write, and the field then reads 3'b000.
- R5: In domains flagged in `EXT_MASK` (default 4'b1001), writing 1 to bit 17 raises `ext_release` for the one cycle after the write. In other domains it never rises. Bit 17 always reads the domain's `st_in_rst` input.
- R6: Bit 3 is the stored force-active override, written and read back at that position and driven on `force_active`.
- R7: While `st_wr_ok` of a domain is low, writes leave its bits 16:14, bit 3 and the release strobe unaffected, but still clear sticky flags.
- R8: Status inputs read at fixed positions: present 0, override-writable 1, functional clock running 2, powered 5, power-down desired 7, halted in debug 10, debug logic powered 19.
- R9: Read data appears on `reg_rdata` in the cycle after the read select. All reserved bits (31:23, 20, 18, 13:11, 9:8, 6, 4) read 0.
- R10: Offset 0x1FC reads `ID_VALUE` (default 32'h3B00_0021) and ignores writes. Any unlisted offset reads 0, and writes to one change nothing.
- R11: Domain i sits at offset 0x100 + 4*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| st_present | input | 4 | Core present, per domain |
| st_wr_ok | input | 4 | Overrides writable, per domain |
| st_clk_on | input | 4 | Functional clock running |
| st_powered | input | 4 | Domain powered |
| st_pd_want | input | 4 | Power-down desired |
| st_halted | input | 4 | Core halted in debug |
| st_dbg_pwr | input | 4 | Debug logic powered |
| st_in_rst | input | 4 | Core held in (extended) reset |
| ev_core_rst | input | 4 | Reset-occurred event pulse |
| ev_pwr_loss | input | 4 | Power-loss event pulse |
| hold_rst | output | 4 | Hold-in-reset mode active |
| block_rst | output | 4 | Block-reset mode active |
| rst_req | output | 4 | One-cycle reset request |
| ext_release | output | 4 | One-cycle extended-reset release |
| force_active | output | 4 | Force-active override |

## Verification
All control outputs are registered. A write clocked at edge N shows on `hold_rst`, `block_rst`, `force_active`, `rst_req` and `ext_release` just after edge N, and the strobes drop after edge N+1. A read clocked at edge N presents its word just after edge N, and an event pulse clocked at edge N is visible to a read clocked at N+1. The bench drives inputs on falling edges and samples one time unit after the rising edge that completes each access. It compares the outputs against a model of the stickies, modes and overrides after every access. That model is updated the same way for random writes, events and status patterns.

// File: rtl/dpd_pkg.sv
`timescale 1ns/1ps
package dpd_pkg;
  localparam int unsigned WORD_W = 32;

  // field positions inside a domain word
  localparam int unsigned P_PRESENT = 0;
  localparam int unsigned P_WROK    = 1;
  localparam int unsigned P_CLKON   = 2;
  localparam int unsigned P_FORCE   = 3;
  localparam int unsigned P_PWRD    = 5;
  localparam int unsigned P_PDWANT  = 7;
  localparam int unsigned P_HALT    = 10;
  localparam int unsigned P_MODE_LO = 14;
  localparam int unsigned P_MODE_HI = 16;
  localparam int unsigned P_REL     = 17;
  localparam int unsigned P_DBGPWR  = 19;
  localparam int unsigned P_LOSS    = 21;
  localparam int unsigned P_OCC     = 22;

  typedef enum logic [2:0] {
    MODE_RUN   = 3'b000,
    MODE_HOLD  = 3'b001,
    MODE_BLOCK = 3'b010,
    MODE_REQ   = 3'b100
  } rst_mode_e;

  typedef struct packed {
    logic present;
    logic wr_ok;
    logic clk_on;
    logic powered;
    logic pd_want;
    logic halted;
    logic dbg_pwr;
    logic in_rst;
  } dom_status_t;
endpackage

// File: rtl/dpd_decode.sv
`timescale 1ns/1ps
module dpd_decode #(
  parameter int unsigned NUM_DOM  = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DOM_BASE = 12'h100,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 12'h1FC
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_DOM-1:0] dom_hit,
  output logic               id_hit
);
  localparam int unsigned STRIDE = 4;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(DOM_BASE + STRIDE * i);
    assign dom_hit[i] = (addr == OFS);
  end

  assign id_hit = (addr == ID_ADDR);
endmodule

// File: rtl/dpd_domain.sv
`timescale 1ns/1ps
module dpd_domain
  import dpd_pkg::*;
#(
  parameter bit EXT_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  dom_status_t       st,
  input  logic              ev_rst,
  input  logic              ev_loss,
  output logic [WORD_W-1:0] rd_word,
  output logic              hold_o,
  output logic              block_o,
  output logic              req_o,
  output logic              rel_o,
  output logic              force_o
);
  logic       occ_q, loss_q, force_q, req_q, hold_q, block_q, rel_q;
  logic [2:0] mode_q, mode_nxt;
  logic       req_nxt, ctl_we;

  assign ctl_we = we & st.wr_ok;

  always_comb begin
    mode_nxt = mode_q;
    req_nxt  = 1'b0;
    if (ctl_we) begin
      if (wdata[P_MODE_HI:P_MODE_LO] == MODE_REQ) begin
        mode_nxt = MODE_RUN;
        req_nxt  = 1'b1;
      end else begin
        mode_nxt = wdata[P_MODE_HI:P_MODE_LO];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= 1'b0;
      loss_q  <= 1'b0;
      force_q <= 1'b0;
      mode_q  <= MODE_RUN;
      req_q   <= 1'b0;
      hold_q  <= 1'b0;
      block_q <= 1'b0;
    end else begin
      occ_q   <= ev_rst  | (occ_q  & ~(we & wdata[P_OCC]));
      loss_q  <= ev_loss | (loss_q & ~(we & wdata[P_LOSS]));
      if (ctl_we) force_q <= wdata[P_FORCE];
      mode_q  <= mode_nxt;
      req_q   <= req_nxt;
      hold_q  <= (mode_nxt == MODE_HOLD);
      block_q <= (mode_nxt == MODE_BLOCK);
    end
  end

  if (EXT_EN) begin : g_ext
    always_ff @(posedge clk) begin
      if (rst) rel_q <= 1'b0;
      else     rel_q <= ctl_we & wdata[P_REL];
    end
    // R5
    rel_cause_chk: assert property (@(posedge clk) disable iff (rst)
      rel_q |-> $past(we && st.wr_ok && wdata[P_REL]));
  end else begin : g_noext
    assign rel_q = 1'b0;
  end

  always_comb begin
    rd_word = '0;
    rd_word[P_PRESENT]           = st.present;
    rd_word[P_WROK]              = st.wr_ok;
    rd_word[P_CLKON]             = st.clk_on;
    rd_word[P_FORCE]             = force_q;
    rd_word[P_PWRD]              = st.powered;
    rd_word[P_PDWANT]            = st.pd_want;
    rd_word[P_HALT]              = st.halted;
    rd_word[P_MODE_HI:P_MODE_LO] = mode_q;
    rd_word[P_REL]               = st.in_rst;
    rd_word[P_DBGPWR]            = st.dbg_pwr;
    rd_word[P_LOSS]              = loss_q;
    rd_word[P_OCC]               = occ_q;
  end

  assign hold_o  = hold_q;
  assign block_o = block_q;
  assign req_o   = req_q;
  assign rel_o   = rel_q;
  assign force_o = force_q;

  // R2
  occ_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_rst |=> occ_q);
  // R2
  loss_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_loss |=> loss_q);
  // R3
  mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hold_q && block_q));
  // R4
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> ($past(ctl_we && wdata[P_MODE_HI:P_MODE_LO] == 3'b100) && mode_q == 3'b000));
  // R7
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !st.wr_ok) |=> ($stable(force_q) && $stable(mode_q) && !req_q));
endmodule

// File: rtl/dpd_readmux.sv
`timescale 1ns/1ps
module dpd_readmux
  import dpd_pkg::*;
#(
  parameter int unsigned NUM_DOM = 4,
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h3B00_0021
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en,
  input  logic [NUM_DOM-1:0]              dom_hit,
  input  logic                            id_hit,
  input  logic [NUM_DOM-1:0][WORD_W-1:0]  dom_words,
  output logic [WORD_W-1:0]               rdata
);
  logic [WORD_W-1:0] sel_word, rdata_q;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_DOM; i++)
      if (dom_hit[i]) sel_word = dom_words[i];
    if (id_hit) sel_word = ID_VALUE;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel_word;
  end

  assign rdata = rdata_q;

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(|dom_hit) && !id_hit) |=> (rdata_q == '0));
  // R10
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && id_hit) |=> (rdata_q == ID_VALUE));
endmodule

// File: rtl/dbg_pwrdom_ctl.sv
`timescale 1ns/1ps
module dbg_pwrdom_ctl
  import dpd_pkg::*;
#(
  parameter int unsigned NUM_DOM  = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DOM_BASE = 12'h100,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 12'h1FC,
  parameter logic [31:0]       ID_VALUE = 32'h3B00_0021,
  parameter logic [NUM_DOM-1:0] EXT_MASK = 4'b1001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_DOM-1:0] st_present,
  input  logic [NUM_DOM-1:0] st_wr_ok,
  input  logic [NUM_DOM-1:0] st_clk_on,
  input  logic [NUM_DOM-1:0] st_powered,
  input  logic [NUM_DOM-1:0] st_pd_want,
  input  logic [NUM_DOM-1:0] st_halted,
  input  logic [NUM_DOM-1:0] st_dbg_pwr,
  input  logic [NUM_DOM-1:0] st_in_rst,
  input  logic [NUM_DOM-1:0] ev_core_rst,
  input  logic [NUM_DOM-1:0] ev_pwr_loss,
  output logic [NUM_DOM-1:0] hold_rst,
  output logic [NUM_DOM-1:0] block_rst,
  output logic [NUM_DOM-1:0] rst_req,
  output logic [NUM_DOM-1:0] ext_release,
  output logic [NUM_DOM-1:0] force_active
);
  logic [NUM_DOM-1:0]             dom_hit;
  logic                           id_hit;
  logic [NUM_DOM-1:0][WORD_W-1:0] dom_words;
  logic                           wr_en, rd_en;

  assign wr_en = reg_sel &  reg_wr;
  assign rd_en = reg_sel & ~reg_wr;

  dpd_decode #(
    .NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W), .DOM_BASE(DOM_BASE), .ID_ADDR(ID_ADDR)
  ) u_dec (
    .addr(reg_addr), .dom_hit(dom_hit), .id_hit(id_hit)
  );

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    dom_status_t st;
    assign st = '{present: st_present[i], wr_ok: st_wr_ok[i], clk_on: st_clk_on[i],
                  powered: st_powered[i], pd_want: st_pd_want[i], halted: st_halted[i],
                  dbg_pwr: st_dbg_pwr[i], in_rst: st_in_rst[i]};
    dpd_domain #(.EXT_EN(EXT_MASK[i])) u_dom (
      .clk(clk), .rst(rst),
      .we(wr_en & dom_hit[i]), .wdata(reg_wdata), .st(st),
      .ev_rst(ev_core_rst[i]), .ev_loss(ev_pwr_loss[i]),
      .rd_word(dom_words[i]),
      .hold_o(hold_rst[i]), .block_o(block_rst[i]), .req_o(rst_req[i]),
      .rel_o(ext_release[i]), .force_o(force_active[i])
    );
  end

  dpd_readmux #(.NUM_DOM(NUM_DOM), .ID_VALUE(ID_VALUE)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .dom_hit(dom_hit), .id_hit(id_hit),
    .dom_words(dom_words), .rdata(reg_rdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (hold_rst == '0 && block_rst == '0 && rst_req == '0 &&
             ext_release == '0 && force_active == '0 && reg_rdata == '0));
  // R10
  miss_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(|dom_hit)) |=> ($stable(force_active) && $stable(hold_rst) &&
                                $stable(block_rst) && rst_req == '0 && ext_release == '0));
endmodule

// File: tb/sim_dbg_pwrdom_ctl.sv
`timescale 1ns/1ps
module sim_dbg_pwrdom_ctl;
  localparam logic [31:0] IDV = 32'h3B00_0021;
  localparam logic [3:0]  EXTM = 4'b1001;

  logic clk = 0, rst = 1;
  logic reg_sel = 0, reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0] st_present = 0, st_wr_ok = 0, st_clk_on = 0, st_powered = 0;
  logic [3:0] st_pd_want = 0, st_halted = 0, st_dbg_pwr = 0, st_in_rst = 0;
  logic [3:0] ev_core_rst = 0, ev_pwr_loss = 0;
  logic [3:0] hold_rst, block_rst, rst_req, ext_release, force_active;

  always #2.5 clk = ~clk;

  dbg_pwrdom_ctl u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] m_occ = 0, m_loss = 0, m_force = 0;
  logic [2:0] m_mode [4] = '{default: 3'b000};
  logic [3:0] x_req = 0, x_rel = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int i);
    logic [31:0] w = '0;
    w[0] = st_present[i]; w[1] = st_wr_ok[i]; w[2] = st_clk_on[i];
    w[3] = m_force[i];    w[5] = st_powered[i]; w[7] = st_pd_want[i];
    w[10] = st_halted[i]; w[16:14] = m_mode[i]; w[17] = st_in_rst[i];
    w[19] = st_dbg_pwr[i]; w[21] = m_loss[i]; w[22] = m_occ[i];
    return w;
  endfunction

  function automatic logic [3:0] exp_mode_vec(logic [2:0] code);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (m_mode[i] == code);
    return v;
  endfunction

  task automatic chk_outs(string req);
    chk({req, " hold"},  {28'd0, hold_rst},     {28'd0, exp_mode_vec(3'b001)});
    chk({req, " block"}, {28'd0, block_rst},    {28'd0, exp_mode_vec(3'b010)});
    chk({req, " force"}, {28'd0, force_active}, {28'd0, m_force});
    chk({req, " req"},   {28'd0, rst_req},      {28'd0, x_req});
    chk({req, " rel"},   {28'd0, ext_release},  {28'd0, x_rel});
  endtask

  // model of one register write (ev = event vector in the same cycle)
  task automatic model_wr(logic [11:0] a, logic [31:0] d);
    x_req = 0; x_rel = 0;
    for (int i = 0; i < 4; i++) begin
      if (a == 12'h100 + 12'(4 * i)) begin
        if (d[22]) m_occ[i] = 0;
        if (d[21]) m_loss[i] = 0;
        if (st_wr_ok[i]) begin
          m_force[i] = d[3];
          if (d[16:14] == 3'b100) begin m_mode[i] = 0; x_req[i] = 1; end
          else m_mode[i] = d[16:14];
          if (EXTM[i] && d[17]) x_rel[i] = 1;
        end
      end
    end
    m_occ = m_occ | ev_core_rst;
    m_loss = m_loss | ev_pwr_loss;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    model_wr(a, d);
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0; ev_core_rst = 0; ev_pwr_loss = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    @(posedge clk); #1;
    reg_sel = 0; d = reg_rdata;
    x_req = 0; x_rel = 0;
  endtask

  task automatic pulse_ev(logic [3:0] r, logic [3:0] l);
    @(negedge clk);
    ev_core_rst = r; ev_pwr_loss = l;
    @(posedge clk); #1;
    ev_core_rst = 0; ev_pwr_loss = 0;
    m_occ |= r; m_loss |= l; x_req = 0; x_rel = 0;
  endtask

  task automatic rd_chk(int i, string req);
    logic [31:0] v;
    rd(12'h100 + 12'(4 * i), v);
    chk(req, v, exp_word(i));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    chk_outs("R1");
    for (int i = 0; i < 4; i++) rd_chk(i, "R1 word zero");
    rd(12'h1FC, v); chk("R10 id", v, IDV);

    // R8 status positions
    st_halted = 4'b0010;
    rd(12'h104, v); chk("R8 halted bit10", v, 32'h0000_0400);
    st_halted = 0; st_dbg_pwr = 4'b0100;
    rd(12'h108, v); chk("R8 dbgpwr bit19", v, 32'h0008_0000);
    st_dbg_pwr = 0;
    st_present = 4'hF; st_clk_on = 4'hA; st_powered = 4'h5; st_pd_want = 4'h3; st_in_rst = 4'h9;
    for (int i = 0; i < 4; i++) rd_chk(i, "R8 R11 status map");

    // R3 modes
    st_wr_ok = 4'hF;
    wr(12'h100, 32'h0000_4000); chk_outs("R3 hold");
    wr(12'h100, 32'h0000_8000); chk_outs("R3 block");
    wr(12'h100, 32'h0000_C000); chk_outs("R3 undefined 011");
    rd_chk(0, "R3 readback 011");
    wr(12'h100, 32'h0001_C000); chk_outs("R3 undefined 111");

    // R4 request pulse
    wr(12'h104, 32'h0001_0000); chk_outs("R4 pulse");
    chk("R4 pulse now", {28'd0, rst_req}, 32'h2);
    @(posedge clk); #1; x_req = 0; chk_outs("R4 pulse end");
    rd_chk(1, "R4 field back to 000");

    // R5 release
    wr(12'h100, 32'h0002_0000); chk("R5 ext dom0", {28'd0, ext_release}, 32'h1);
    @(posedge clk); #1; chk("R5 one cycle", {28'd0, ext_release}, 32'h0);
    wr(12'h104, 32'h0002_0000); chk("R5 no ext dom1", {28'd0, ext_release}, 32'h0);
    wr(12'h10C, 32'h0002_0000); chk("R5 ext dom3", {28'd0, ext_release}, 32'h8);

    // R6 force-active
    wr(12'h108, 32'h0000_0008); chk_outs("R6 force"); rd_chk(2, "R6 readback");

    // R7 gate, sticky clear still works
    pulse_ev(4'b0100, 4'b0000);
    st_wr_ok = 4'b1011;
    wr(12'h108, 32'h0041_4000); chk_outs("R7 gated");
    rd_chk(2, "R7 gated readback");
    chk("R7 sticky cleared", {31'd0, m_occ[2]}, 32'h0);
    st_wr_ok = 4'hF;

    // R2 sticky behaviour
    pulse_ev(4'b1000, 4'b1000); rd_chk(3, "R2 set");
    wr(12'h10C, 32'h0); rd_chk(3, "R2 write0 keeps");
    wr(12'h10C, 32'h0040_0000); rd_chk(3, "R2 clear occ only");
    ev_pwr_loss = 4'b1000;
    wr(12'h10C, 32'h0020_0000); rd_chk(3, "R2 set wins");
    chk("R2 set wins flag", {31'd0, m_loss[3]}, 32'h1);

    // R10 unlisted / id
    wr(12'h110, 32'hFFFF_FFFF); chk_outs("R10 unlisted write");
    rd(12'h110, v); chk("R10 unlisted read", v, 32'h0);
    rd(12'h1F8, v); chk("R10 unlisted read 1F8", v, 32'h0);
    wr(12'h1FC, 32'h0); rd(12'h1FC, v); chk("R10 id unwritable", v, IDV);
    for (int i = 0; i < 4; i++) rd_chk(i, "R10 no side effect");

    // R9 reserved bits
    wr(12'h104, 32'hFFFF_FFFF); rd_chk(1, "R9 reserved zero");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom_range(0, 9);
      int d  = $urandom_range(0, 3);
      @(negedge clk);
      {st_present, st_wr_ok, st_clk_on, st_powered} = 16'($urandom);
      {st_pd_want, st_halted, st_dbg_pwr, st_in_rst} = 16'($urandom);
      if (op < 4) begin
        logic [31:0] wd = $urandom;
        if ($urandom_range(0, 3) == 0) wd[16:14] = 3'b100;
        if ($urandom_range(0, 7) == 0) begin ev_core_rst = 4'($urandom); ev_pwr_loss = 4'($urandom); end
        wr((op == 3 && d == 0) ? 12'h1F0 : 12'h100 + 12'(4 * d), wd);
        chk_outs("R2 R3 R4 R5 R6 R7 random write");
      end else if (op < 6) begin
        pulse_ev(4'($urandom), 4'($urandom));
        chk_outs("R2 random event");
      end else begin
        rd_chk(d, "R8 R9 R11 random read");
        chk_outs("R4 R5 idle");
      end
    end
    finish_run();
  end
endmodule